// File: doc/BRIEF.md
# Dual FIFO Host Access Controller

This block connects a processor bus to two external 16-bit input FIFOs that outside data sources normally fill. On the read side it decodes the upper offset bits of a FIFO-window access to strobe lane A, lane B, or both. It returns the popped data one cycle later, placed in the correct half of a 32-bit word. A separate status select returns the two FIFOs' active-low level flags, packed into one word.

On the write side the FIFOs' write clock and write enable normally come from the external sources. When the 32-bit mode input is high, both FIFOs follow source B's controls. The programmable flag offsets are loaded serially by the processor. An asynchronous-type write to the takeover offset hands the write clock and enable to the processor. Each write to the load offset then produces one enable-and-clock pulse that shifts one data bit into each FIFO. A write to the release offset hands control back. A load write whose guard bits are not zero is refused and reported on an error pulse.

Top module: `dual_fifo_host_ctrl`

## Requirements
- R1: A combined read returns lane A's popped word on bits 15:0 and lane B's popped word on bits 31:16.
- R2: The top two offset bits of a FIFO-window read select the lanes. 00 selects A only, 01 selects B only, 10 selects both, and 11 selects neither. The read strobe of each selected lane is high during the request cycle, and the strobes of unselected lanes stay low. In the following cycle the valid output is high and the data halves of unselected lanes are zero. The valid output is low one cycle after any non-read cycle.
- R3: One cycle after a status read, bits 11:8 hold lane A's active-low flags and bits 15:12 hold lane B's. The flag order from the low bit is not-empty, not-almost-empty, not-almost-full, not-full. The flags are those present at the request edge. Bits 7:0 and 31:16 are zero.
- R4: An asynchronous-type write to offset 0x800000 gives the write clock and enable to the processor from the next cycle. A synchronous-type write to that offset has no effect.
- R5: Any write to offset 0x00C000 returns the multiplexer to normal mode from the next cycle and cancels a pulse in progress.
- R6: After reset the multiplexer is in normal mode, and valid and error are low.
- R7: In normal mode, FIFO B's write clock and enable follow source B. FIFO A's write clock and enable follow source A when the 32-bit mode input is low, and follow source B when it is high. In processor mode, the external controls have no effect.
- R8: In processor mode, a write to offset 0 with clear guard bits produces the following. One cycle later both write enables are high, both write clocks are low, lane A's serial bit equals data bit 19, and lane B's serial bit equals data bit 23. Two cycles later both write clocks are high. Three cycles later the enables and clocks are low.
- R9: A load write that arrives while a pulse is still in flight is ignored. The next load write can be accepted three cycles after the previous accepted one.
- R10: In processor mode, a load write with any of data bits 17, 18, 21 or 22 set raises the error output for exactly the next cycle and produces no pulse.
- R11: In normal mode, a write to offset 0 produces no pulse and no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_cs | input | 1 | FIFO window access request |
| stat_cs | input | 1 | Status word read request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_async | input | 1 | 1 = asynchronous-type access |
| bus_addr | input | ADDR_W | Offset within the FIFO window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after request |
| mode32 | input | 1 | Source B controls both FIFOs |
| ext_a_wclk | input | 1 | Source A write clock |
| ext_a_wen | input | 1 | Source A write enable |
| ext_b_wclk | input | 1 | Source B write clock |
| ext_b_wen | input | 1 | Source B write enable |
| fifo_a_wclk | output | 1 | FIFO A write clock |
| fifo_a_wen | output | 1 | FIFO A write enable |
| fifo_b_wclk | output | 1 | FIFO B write clock |
| fifo_b_wen | output | 1 | FIFO B write enable |
| fifo_a_sdi | output | 1 | FIFO A serial offset bit |
| fifo_b_sdi | output | 1 | FIFO B serial offset bit |
| fifo_a_ren | output | 1 | FIFO A pop strobe |
| fifo_b_ren | output | 1 | FIFO B pop strobe |
| fifo_a_dout | input | 16 | FIFO A output word |
| fifo_b_dout | input | 16 | FIFO B output word |
| fifo_a_flags_n | input | 4 | FIFO A active-low level flags |
| fifo_b_flags_n | input | 4 | FIFO B active-low level flags |
| cpu_owns_wr | output | 1 | Processor drives the write controls |
| load_err | output | 1 | Refused serial-load write, one-cycle pulse |

## Verification
Several results are due at fixed points relative to the request edge:

- The read strobes and the write-control multiplexer outputs are combinational, so the bench samples them 1 ns after the inputs change, before the edge.
- Read data, status words, mode changes and the error pulse are registered once. The bench samples them 1 ns after the request edge.
- The serial pulse spans three edges: enable and data after the first, clock high after the second, and all low after the third. Each is sampled after its own edge.

The FIFO stubs in the bench count their own pops and shifts. The bench checks those counts against tallies it keeps from the requirements.

// File: rtl/dfh_pkg.sv
package dfh_pkg;
  localparam int LANE_W   = 16;
  localparam int WORD_W   = 2 * LANE_W;
  localparam int FLAG_N   = 4;
  localparam int STAT_LSB = 8;
  localparam int SER_A_BIT = LANE_W + 3;
  localparam int SER_B_BIT = LANE_W + 7;
  localparam logic [WORD_W-1:0] GUARD_MASK =
    (WORD_W'(1) << (LANE_W + 1)) | (WORD_W'(1) << (LANE_W + 2)) |
    (WORD_W'(1) << (LANE_W + 5)) | (WORD_W'(1) << (LANE_W + 6));

  typedef enum logic [1:0] {
    LANE_A    = 2'b00,
    LANE_B    = 2'b01,
    LANE_AB   = 2'b10,
    LANE_NONE = 2'b11
  } lane_e;

  function automatic logic guard_clear(input logic [WORD_W-1:0] d);
    return (d & GUARD_MASK) == '0;
  endfunction

  function automatic logic [WORD_W-1:0] lane_merge(input lane_e l,
      input logic [LANE_W-1:0] a, input logic [LANE_W-1:0] b);
    case (l)
      LANE_A:  return {{LANE_W{1'b0}}, a};
      LANE_B:  return {b, {LANE_W{1'b0}}};
      LANE_AB: return {b, a};
      default: return '0;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] status_word(
      input logic [FLAG_N-1:0] a_n, input logic [FLAG_N-1:0] b_n);
    logic [WORD_W-1:0] w;
    w = '0;
    w[STAT_LSB +: FLAG_N]          = a_n;
    w[STAT_LSB + FLAG_N +: FLAG_N] = b_n;
    return w;
  endfunction
endpackage

// File: rtl/dfh_decode.sv
module dfh_decode
  import dfh_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter logic [ADDR_W-1:0] RELEASE_OFS = 24'h00C000
) (
  input  logic              cs,
  input  logic              stat_cs,
  input  logic              we,
  input  logic              async_acc,
  input  logic [ADDR_W-1:0] addr,
  output logic              rd_fifo,
  output logic              rd_stat,
  output lane_e             rd_lane,
  output logic              wr_take,
  output logic              wr_rel,
  output logic              wr_load
);
  localparam logic [ADDR_W-1:0] TAKE_OFS = {2'b10, {(ADDR_W-2){1'b0}}};
  localparam logic [ADDR_W-1:0] LOAD_OFS = '0;

  assign rd_fifo = cs && !we;
  assign rd_stat = stat_cs && !we && !cs;
  assign rd_lane = lane_e'(addr[ADDR_W-1 -: 2]);
  assign wr_take = cs && we && async_acc && (addr == TAKE_OFS);
  assign wr_rel  = cs && we && (addr == RELEASE_OFS);
  assign wr_load = cs && we && (addr == LOAD_OFS);
endmodule

// File: rtl/dfh_loadseq.sv
module dfh_loadseq
  import dfh_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_take,
  input  logic              wr_rel,
  input  logic              wr_load,
  input  logic [WORD_W-1:0] wdata,
  output logic              cpu_owns,
  output logic              cpu_wclk,
  output logic              cpu_wen,
  output logic              sdi_a,
  output logic              sdi_b,
  output logic              load_err,
  output logic              load_accept,
  output logic              load_reject
);
  logic owns_q, wen_q, wclk_q, sa_q, sb_q, err_q;
  logic guard_ok;

  assign guard_ok    = guard_clear(wdata);
  assign load_accept = wr_load && owns_q && guard_ok && !wen_q;
  assign load_reject = wr_load && owns_q && !guard_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      owns_q <= 1'b0;
      wen_q  <= 1'b0;
      wclk_q <= 1'b0;
      sa_q   <= 1'b0;
      sb_q   <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      err_q <= load_reject;
      if (wr_rel) begin
        owns_q <= 1'b0;
        wen_q  <= 1'b0;
        wclk_q <= 1'b0;
      end else begin
        if (wr_take) owns_q <= 1'b1;
        if (load_accept) begin
          wen_q  <= 1'b1;
          wclk_q <= 1'b0;
          sa_q   <= wdata[SER_A_BIT];
          sb_q   <= wdata[SER_B_BIT];
        end else if (wen_q && !wclk_q) begin
          wclk_q <= 1'b1;
        end else if (wclk_q) begin
          wclk_q <= 1'b0;
          wen_q  <= 1'b0;
        end
      end
    end
  end

  assign cpu_owns = owns_q;
  assign cpu_wclk = wclk_q;
  assign cpu_wen  = wen_q;
  assign sdi_a    = sa_q;
  assign sdi_b    = sb_q;
  assign load_err = err_q;
endmodule

// File: rtl/dfh_wmux.sv
module dfh_wmux #(
  parameter int CHANNELS = 2
) (
  input  logic                cpu_owns,
  input  logic                mode32,
  input  logic                cpu_wclk,
  input  logic                cpu_wen,
  input  logic [CHANNELS-1:0] ext_wclk,
  input  logic [CHANNELS-1:0] ext_wen,
  output logic [CHANNELS-1:0] out_wclk,
  output logic [CHANNELS-1:0] out_wen
);
  localparam int LEAD = CHANNELS - 1;

  for (genvar ch = 0; ch < CHANNELS; ch++) begin : g_ch
    logic src_clk, src_en;
    if (ch == LEAD) begin : g_lead
      assign src_clk = ext_wclk[ch];
      assign src_en  = ext_wen[ch];
    end else begin : g_follow
      assign src_clk = mode32 ? ext_wclk[LEAD] : ext_wclk[ch];
      assign src_en  = mode32 ? ext_wen[LEAD]  : ext_wen[ch];
    end
    assign out_wclk[ch] = cpu_owns ? cpu_wclk : src_clk;
    assign out_wen[ch]  = cpu_owns ? cpu_wen  : src_en;
  end
endmodule

// File: rtl/dfh_rdpath.sv
module dfh_rdpath
  import dfh_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_fifo,
  input  logic              rd_stat,
  input  lane_e             rd_lane,
  input  logic [LANE_W-1:0] a_dout,
  input  logic [LANE_W-1:0] b_dout,
  input  logic [FLAG_N-1:0] a_flags_n,
  input  logic [FLAG_N-1:0] b_flags_n,
  output logic              a_ren,
  output logic              b_ren,
  output logic [WORD_W-1:0] rdata,
  output logic              rvalid
);
  logic              valid_q, stat_sel_q;
  lane_e             lane_q;
  logic [WORD_W-1:0] stat_q;

  assign a_ren = rd_fifo && (rd_lane == LANE_A || rd_lane == LANE_AB);
  assign b_ren = rd_fifo && (rd_lane == LANE_B || rd_lane == LANE_AB);

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q    <= 1'b0;
      stat_sel_q <= 1'b0;
      lane_q     <= LANE_NONE;
      stat_q     <= '0;
    end else begin
      valid_q    <= rd_fifo || rd_stat;
      stat_sel_q <= rd_stat;
      lane_q     <= rd_lane;
      if (rd_stat) stat_q <= status_word(a_flags_n, b_flags_n);
    end
  end

  always_comb begin
    if (!valid_q)        rdata = '0;
    else if (stat_sel_q) rdata = stat_q;
    else                 rdata = lane_merge(lane_q, a_dout, b_dout);
  end
  assign rvalid = valid_q;
endmodule

// File: rtl/dual_fifo_host_ctrl.sv
module dual_fifo_host_ctrl
  import dfh_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter logic [ADDR_W-1:0] RELEASE_OFS = 24'h00C000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_cs,
  input  logic              stat_cs,
  input  logic              bus_we,
  input  logic              bus_async,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_rvalid,
  input  logic              mode32,
  input  logic              ext_a_wclk,
  input  logic              ext_a_wen,
  input  logic              ext_b_wclk,
  input  logic              ext_b_wen,
  output logic              fifo_a_wclk,
  output logic              fifo_a_wen,
  output logic              fifo_b_wclk,
  output logic              fifo_b_wen,
  output logic              fifo_a_sdi,
  output logic              fifo_b_sdi,
  output logic              fifo_a_ren,
  output logic              fifo_b_ren,
  input  logic [15:0]       fifo_a_dout,
  input  logic [15:0]       fifo_b_dout,
  input  logic [3:0]        fifo_a_flags_n,
  input  logic [3:0]        fifo_b_flags_n,
  output logic              cpu_owns_wr,
  output logic              load_err
);
  logic  rd_fifo, rd_stat, wr_take, wr_rel, wr_load;
  lane_e rd_lane;
  logic  cpu_wclk, cpu_wen, load_accept, load_reject;
  logic [1:0] mux_wclk, mux_wen;

  dfh_decode #(.ADDR_W(ADDR_W), .RELEASE_OFS(RELEASE_OFS)) u_dec (
    .cs(bus_cs), .stat_cs(stat_cs), .we(bus_we), .async_acc(bus_async),
    .addr(bus_addr), .rd_fifo(rd_fifo), .rd_stat(rd_stat), .rd_lane(rd_lane),
    .wr_take(wr_take), .wr_rel(wr_rel), .wr_load(wr_load));

  dfh_loadseq u_seq (
    .clk(clk), .rst(rst), .wr_take(wr_take), .wr_rel(wr_rel),
    .wr_load(wr_load), .wdata(bus_wdata), .cpu_owns(cpu_owns_wr),
    .cpu_wclk(cpu_wclk), .cpu_wen(cpu_wen), .sdi_a(fifo_a_sdi),
    .sdi_b(fifo_b_sdi), .load_err(load_err), .load_accept(load_accept),
    .load_reject(load_reject));

  dfh_wmux #(.CHANNELS(2)) u_mux (
    .cpu_owns(cpu_owns_wr), .mode32(mode32), .cpu_wclk(cpu_wclk),
    .cpu_wen(cpu_wen), .ext_wclk({ext_b_wclk, ext_a_wclk}),
    .ext_wen({ext_b_wen, ext_a_wen}), .out_wclk(mux_wclk), .out_wen(mux_wen));

  assign fifo_a_wclk = mux_wclk[0];
  assign fifo_b_wclk = mux_wclk[1];
  assign fifo_a_wen  = mux_wen[0];
  assign fifo_b_wen  = mux_wen[1];

  dfh_rdpath u_rd (
    .clk(clk), .rst(rst), .rd_fifo(rd_fifo), .rd_stat(rd_stat),
    .rd_lane(rd_lane), .a_dout(fifo_a_dout), .b_dout(fifo_b_dout),
    .a_flags_n(fifo_a_flags_n), .b_flags_n(fifo_b_flags_n),
    .a_ren(fifo_a_ren), .b_ren(fifo_b_ren), .rdata(bus_rdata),
    .rvalid(bus_rvalid));
endmodule

// File: rtl/dfh_checker.sv
module dfh_checker #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_cs,
  input logic              stat_cs,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_rdata,
  input logic              bus_rvalid,
  input logic              fifo_a_ren,
  input logic              fifo_b_ren,
  input logic              cpu_wclk,
  input logic              cpu_wen,
  input logic              cpu_owns_wr,
  input logic              load_accept,
  input logic              load_reject,
  input logic              wr_take,
  input logic              wr_rel
);
  a_r2_strobe_needs_read: assert property (@(posedge clk) disable iff (rst)
    (fifo_a_ren || fifo_b_ren) |-> (bus_cs && !bus_we));
  a_r2_valid_follows_read: assert property (@(posedge clk) disable iff (rst)
    (bus_cs && !bus_we) |=> bus_rvalid);
  a_r2_lane_a_top_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_cs && !bus_we && bus_addr[ADDR_W-1 -: 2] == 2'b00) |=> (bus_rdata[31:16] == 16'h0));
  a_r3_status_pad_zero: assert property (@(posedge clk) disable iff (rst)
    (stat_cs && !bus_we && !bus_cs) |=> (bus_rdata[7:0] == 8'h0 && bus_rdata[31:16] == 16'h0));
  a_r4_takeover_owns: assert property (@(posedge clk) disable iff (rst)
    wr_take |=> cpu_owns_wr);
  a_r5_release_drops: assert property (@(posedge clk) disable iff (rst)
    wr_rel |=> (!cpu_owns_wr && !cpu_wen && !cpu_wclk));
  a_r8_clock_after_setup: assert property (@(posedge clk) disable iff (rst)
    $rose(cpu_wclk) |-> (cpu_wen && $past(cpu_wen)));
  a_r8_clock_one_cycle: assert property (@(posedge clk) disable iff (rst)
    cpu_wclk |=> !cpu_wclk);
  a_r9_no_accept_when_busy: assert property (@(posedge clk) disable iff (rst)
    load_accept |-> !cpu_wen);
  a_r10_reject_no_pulse: assert property (@(posedge clk) disable iff (rst)
    load_reject |=> !$rose(cpu_wen));
endmodule

bind dual_fifo_host_ctrl dfh_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .bus_cs(bus_cs), .stat_cs(stat_cs), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
  .fifo_a_ren(fifo_a_ren), .fifo_b_ren(fifo_b_ren), .cpu_wclk(cpu_wclk),
  .cpu_wen(cpu_wen), .cpu_owns_wr(cpu_owns_wr), .load_accept(load_accept),
  .load_reject(load_reject), .wr_take(wr_take), .wr_rel(wr_rel));

// File: tb/sim_dual_fifo_host_ctrl.sv
module sim_dual_fifo_host_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_cs = 0, stat_cs = 0, bus_we = 0, bus_async = 0;
  logic [23:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic bus_rvalid;
  logic mode32 = 0;
  logic ext_a_wclk = 0, ext_a_wen = 0, ext_b_wclk = 0, ext_b_wen = 0;
  logic fifo_a_wclk, fifo_a_wen, fifo_b_wclk, fifo_b_wen;
  logic fifo_a_sdi, fifo_b_sdi, fifo_a_ren, fifo_b_ren;
  logic [15:0] fifo_a_dout, fifo_b_dout;
  logic [3:0] fifo_a_flags_n = 4'hF, fifo_b_flags_n = 4'hF;
  logic cpu_owns_wr, load_err;

  int total = 0, fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  dual_fifo_host_ctrl u0 (.*);

  function automatic logic [15:0] a_pat(input int n);
    return 16'(n * 37 + 16'h1200);
  endfunction
  function automatic logic [15:0] b_pat(input int n);
    return 16'(n * 91 + 16'h8800);
  endfunction

  int a_cnt = 0, b_cnt = 0;
  always_ff @(posedge clk) begin
    if (rst) begin
      a_cnt <= 0; b_cnt <= 0;
      fifo_a_dout <= '0; fifo_b_dout <= '0;
    end else begin
      if (fifo_a_ren) begin a_cnt <= a_cnt + 1; fifo_a_dout <= a_pat(a_cnt + 1); end
      if (fifo_b_ren) begin b_cnt <= b_cnt + 1; fifo_b_dout <= b_pat(b_cnt + 1); end
    end
  end

  logic [15:0] a_sr = '0, b_sr = '0;
  int a_shifts = 0, b_shifts = 0;
  always @(posedge fifo_a_wclk) if (fifo_a_wen) begin a_sr <= {a_sr[14:0], fifo_a_sdi}; a_shifts <= a_shifts + 1; end
  always @(posedge fifo_b_wclk) if (fifo_b_wen) begin b_sr <= {b_sr[14:0], fifo_b_sdi}; b_shifts <= b_shifts + 1; end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic put(input logic c, input logic s, input logic w, input logic a,
                     input logic [23:0] ad, input logic [31:0] d);
    @(negedge clk);
    bus_cs = c; stat_cs = s; bus_we = w; bus_async = a; bus_addr = ad; bus_wdata = d;
  endtask
  task automatic step();
    @(posedge clk); #1;
  endtask
  task automatic idle();
    put(0, 0, 0, 0, 24'h0, 32'h0);
  endtask

  function automatic logic [31:0] ld(input logic ba, input logic bb);
    return (32'(ba) << 19) | (32'(bb) << 23);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; fails++;
      $display("FAIL R6 watchdog act=running exp=done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    int na, nb, sa, sb;
    logic [7:0] pa, pb;
    logic [3:0] gbits [4];
    gbits[0] = 4'd1; gbits[1] = 4'd2; gbits[2] = 4'd5; gbits[3] = 4'd6;
    na = 0; nb = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    #1;
    chk("R6 owns", 32'(cpu_owns_wr), 0);
    chk("R6 rvalid", 32'(bus_rvalid), 0);
    chk("R6 err", 32'(load_err), 0);

    // R2 / R1: lane decode sweep
    for (int rep = 0; rep < 3; rep++) begin
      for (int code = 0; code < 4; code++) begin
        logic ea, eb;
        logic [31:0] exp;
        ea = (code == 0 || code == 2);
        eb = (code == 1 || code == 2);
        put(1, 0, 0, 0, {code[1:0], 22'h0}, 32'h0);
        #1;
        chk("R2 a strobe", 32'(fifo_a_ren), 32'(ea));
        chk("R2 b strobe", 32'(fifo_b_ren), 32'(eb));
        step();
        if (ea) na++;
        if (eb) nb++;
        exp = {eb ? b_pat(nb) : 16'h0, ea ? a_pat(na) : 16'h0};
        chk("R2 rvalid", 32'(bus_rvalid), 1);
        chk(code == 2 ? "R1 combined data" : "R2 lane data", bus_rdata, exp);
      end
    end
    idle(); step();
    chk("R2 rvalid idle", 32'(bus_rvalid), 0);
    chk("R2 a pop count", 32'(a_cnt), 32'(na));
    chk("R2 b pop count", 32'(b_cnt), 32'(nb));

    // R3: status sweep over every flag combination
    for (int v = 0; v < 256; v++) begin
      put(0, 1, 0, 0, 24'h0, 32'h0);
      fifo_a_flags_n = v[3:0]; fifo_b_flags_n = v[7:4];
      step();
      fifo_a_flags_n = ~v[3:0];
      chk("R3 status", bus_rdata, 32'(v) << 8);
    end
    idle(); step();

    // R11: load write in normal mode
    sa = a_shifts;
    put(1, 0, 1, 1, 24'h0, ld(1, 1)); step();
    chk("R11 no enable", 32'(fifo_a_wen), 0);
    chk("R11 no err", 32'(load_err), 0);
    idle(); step(); step();
    chk("R11 no shift", 32'(a_shifts), 32'(sa));

    // R4: synchronous write to takeover offset ignored, async accepted
    put(1, 0, 1, 0, 24'h800000, 32'h0); step();
    chk("R4 sync ignored", 32'(cpu_owns_wr), 0);
    put(1, 0, 1, 1, 24'h800000, 32'h0); step();
    chk("R4 takeover", 32'(cpu_owns_wr), 1);
    idle(); step();

    // R7: external controls ignored in processor mode
    ext_a_wen = 1; ext_b_wen = 1; ext_a_wclk = 1; ext_b_wclk = 1; #1;
    chk("R7 cpu mode a", {30'h0, fifo_a_wclk, fifo_a_wen}, 0);
    chk("R7 cpu mode b", {30'h0, fifo_b_wclk, fifo_b_wen}, 0);
    ext_a_wen = 0; ext_b_wen = 0; ext_a_wclk = 0; ext_b_wclk = 0;

    // R8: serial load with detailed pulse timing on first bit
    pa = 8'b1011_0010; pb = 8'b0110_1101;
    sa = a_shifts; sb = b_shifts;
    for (int i = 7; i >= 0; i--) begin
      put(1, 0, 1, 1, 24'h0, ld(pa[i], pb[i])); step();
      if (i == 7) begin
        chk("R8 setup", {28'h0, fifo_a_wen, fifo_b_wen, fifo_a_wclk, fifo_b_wclk}, 32'hC);
        chk("R8 serial bits", {30'h0, fifo_a_sdi, fifo_b_sdi}, {30'h0, pa[7], pb[7]});
      end
      idle(); step();
      if (i == 7) chk("R8 strobe", {28'h0, fifo_a_wen, fifo_b_wen, fifo_a_wclk, fifo_b_wclk}, 32'hF);
      step();
      if (i == 7) chk("R8 end", {28'h0, fifo_a_wen, fifo_b_wen, fifo_a_wclk, fifo_b_wclk}, 32'h0);
    end
    chk("R8 a offset", {24'h0, a_sr[7:0]}, {24'h0, pa});
    chk("R8 b offset", {24'h0, b_sr[7:0]}, {24'h0, pb});
    chk("R8 shift count", 32'(a_shifts - sa + b_shifts - sb), 16);

    // R9: second write during pulse is ignored
    sa = a_shifts;
    put(1, 0, 1, 1, 24'h0, ld(1, 0)); step();
    put(1, 0, 1, 1, 24'h0, ld(0, 1)); step();
    chk("R9 bit held", {30'h0, fifo_a_sdi, fifo_b_sdi}, 32'h2);
    idle(); step(); step(); step();
    chk("R9 one shift", 32'(a_shifts - sa), 1);
    chk("R9 last bit", 32'(a_sr[0]), 1);

    // R10: each guard bit refuses the write
    for (int g = 0; g < 4; g++) begin
      sa = a_shifts;
      put(1, 0, 1, 1, 24'h0, ld(1, 1) | (32'h1 << (16 + gbits[g]))); step();
      chk("R10 err", 32'(load_err), 1);
      chk("R10 no enable", 32'(fifo_a_wen), 0);
      idle(); step();
      chk("R10 err one cycle", 32'(load_err), 0);
      step();
      chk("R10 no shift", 32'(a_shifts), 32'(sa));
    end

    // R5: release mid-pulse
    put(1, 0, 1, 1, 24'h0, ld(1, 1)); step();
    put(1, 0, 1, 0, 24'h00C000, 32'h0); step();
    chk("R5 released", 32'(cpu_owns_wr), 0);
    chk("R5 pulse cancelled", {30'h0, fifo_a_wen, fifo_a_wclk}, 0);
    idle(); step();

    // R7: normal-mode multiplexer sweep
    for (int m = 0; m < 2; m++) begin
      for (int v = 0; v < 16; v++) begin
        logic [1:0] ea, eb;
        @(negedge clk);
        mode32 = m[0];
        {ext_b_wclk, ext_b_wen, ext_a_wclk, ext_a_wen} = v[3:0];
        #1;
        eb = v[3:2];
        ea = m[0] ? v[3:2] : v[1:0];
        chk("R7 a ctl", {30'h0, fifo_a_wclk, fifo_a_wen}, {30'h0, ea});
        chk("R7 b ctl", {30'h0, fifo_b_wclk, fifo_b_wen}, {30'h0, eb});
      end
    end

    finished = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule